// File: doc/BRIEF.md
# Telecommand Codeblock De-randomiser

This block strips the pseudo-random whitening from telecommand information bits once the channel decoder has corrected them and removed their error-control bits. The bits arrive serially, one per clock, while `bit_vld` is high. The block XORs each bit with the output of an 8-stage feedback shift register and gathers the result into 56-bit codeblock fields. For every finished field it raises `blk_vld` for one cycle.

Three strobes from the surrounding receiver steer the generator. A start-sequence strobe begins a frame. A decode-failure strobe or a channel-loss strobe ends it. Outside a frame the generator rests in its all-ones state. Within a frame it runs without a break across consecutive codeblocks. The enable input chooses between restoring the data and passing it through unchanged.

The controller has two states. `ST_HUNT` waits for a start sequence. `ST_RUN` accepts bits. There are four transitions. T_START goes from `ST_HUNT` to `ST_RUN` on the start strobe. T_ABORT goes from `ST_RUN` to `ST_HUNT` on a decode failure or a channel loss. T_RESTART goes from `ST_RUN` back to `ST_RUN` when a new start strobe arrives during a frame. T_STAY keeps the current state when no strobe is present.

Top module: `tc_derand`

## Requirements
- R1: After reset, `blk_vld` is 0, `blk_data` is all zeros, the controller is in `ST_HUNT` and the generator holds 8'hFF.
- R2: In `ST_HUNT`, bits offered on `bit_vld` are ignored. They produce no `blk_vld` and do not move the generator, so the first block after a later start is restored from 8'hFF.
- R3: A cycle with `sos_det` high (and neither abort strobe) loads 8'hFF into the generator, discards any partial block and enters `ST_RUN`. A bit offered in that same cycle is ignored.
- R4: The pattern bit is stage 0 of the generator. For each accepted bit the state s becomes {^(s & 8'h5F), s[7:1]}, which realises x^8+x^6+x^4+x^3+x^2+x+1.
- R5: With `derand_en` = 1, each accepted bit is output as `bit_in` XOR pattern bit. The first bit of a block lands in `blk_data[55]` and the 56th in `blk_data[0]`.
- R6: With `derand_en` = 0, bits pass through unchanged while the generator still advances one step per accepted bit.
- R7: `blk_vld` is high for exactly one cycle, in the cycle after the 56th accepted bit. `blk_data` holds its value until the next block completes.
- R8: Within one frame the generator is never reloaded between codeblocks. Block k of a frame uses pattern steps 56k to 56k+55.
- R9: `dec_fail` returns the controller to `ST_HUNT` and the generator to 8'hFF and discards the partial block. A bit offered in that cycle is ignored.
- R10: `chan_lost` has the same effect as `dec_fail`.
- R11: When an abort strobe and `sos_det` arrive in the same cycle, the abort wins and the block stays in `ST_HUNT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| derand_en | input | 1 | 1 = remove whitening, 0 = pass bits through |
| sos_det | input | 1 | Start sequence found (strobe) |
| dec_fail | input | 1 | Codeblock failed to decode (strobe) |
| chan_lost | input | 1 | Input channel lost (strobe) |
| bit_vld | input | 1 | `bit_in` carries a decoded information bit |
| bit_in | input | 1 | Decoded information bit |
| blk_vld | output | 1 | One-cycle strobe: `blk_data` completed |
| blk_data | output | 56 | Restored codeblock information field, first bit in MSB |

## Verification
A generator state that is wrong by even one step, or that fails to reload to all-ones, corrupts roughly half the bits of the next 56-bit field. This shows at the ports within at most 56 accepted bits, at the first `blk_vld` after the fault. A wrong bit counter or a wrong controller state shows as a missing, extra or misplaced `blk_vld`. The bench therefore whitens known fields with an independent model of the generator and compares every completed block, including the blocks that follow failures, restarts and disabled stretches.

// File: rtl/tc_derand_pkg.sv
package tc_derand_pkg;

    // information bits per codeblock
    localparam int unsigned BLK_BITS  = 56;
    // pattern generator geometry
    localparam int unsigned GEN_W     = 8;
    localparam logic [7:0]  GEN_TAPS  = 8'h5F;
    localparam int unsigned CNT_W     = $clog2(BLK_BITS);

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } tc_state_e;

endpackage

// File: rtl/tc_derand_gen.sv
module tc_derand_gen #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] TAPS = 8'h5F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic         pat_bit,
    output logic [W-1:0] gen_state
);

    localparam logic [W-1:0] SEED = '1;

    logic [W-1:0] state_q;
    logic [W-1:0] state_nx;
    logic         fb;

    always_comb begin
        fb       = ^(state_q & TAPS);
        state_nx = {fb, state_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_nx;
        end
    end

    assign pat_bit   = state_q[0];
    assign gen_state = state_q;

    // R4: one step per accepted bit, shift right with feedback into MSB
    a_r4_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (state_q[W-2:0] == $past(state_q[W-1:1])));

    // R4: the state never locks up at zero
    a_r4_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/tc_derand_deser.sv
module tc_derand_deser #(
    parameter int unsigned N = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic         blk_vld,
    output logic [N-1:0] blk_data
);

    localparam int unsigned CW   = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;
    logic [N-2:0]  shreg_q;
    logic          done;

    assign done = shift && (cnt_q == LAST);

    // bit counter within the current codeblock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (shift) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // serial to parallel, first bit ends up in the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (shift) begin
            shreg_q <= {shreg_q[N-3:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_vld  <= 1'b0;
            blk_data <= '0;
        end else begin
            blk_vld <= done;
            if (done) begin
                blk_data <= {shreg_q, din};
            end
        end
    end

    // R7: counter stays inside one codeblock
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: output word held between completions
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_vld |-> $stable(blk_data));

endmodule

// File: rtl/tc_derand_ctrl.sv
module tc_derand_ctrl
    import tc_derand_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sos_det,
    input  logic      dec_fail,
    input  logic      chan_lost,
    input  logic      bit_vld,
    output tc_state_e state,
    output logic      gen_load,
    output logic      accept,
    output logic      blk_clr
);

    tc_state_e state_q;
    tc_state_e state_nx;
    logic      abort;

    assign abort = dec_fail || chan_lost;

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (abort) begin
                    state_nx = ST_HUNT;       // T_STAY, abort wins
                end else if (sos_det) begin
                    state_nx = ST_RUN;        // T_START
                end
            end
            ST_RUN: begin
                if (abort) begin
                    state_nx = ST_HUNT;       // T_ABORT
                end else if (sos_det) begin
                    state_nx = ST_RUN;        // T_RESTART
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_nx;
        end
    end

    // control outputs
    always_comb begin
        gen_load = 1'b0;
        accept   = 1'b0;
        blk_clr  = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                gen_load = abort || sos_det;
                blk_clr  = abort || sos_det;
            end
            ST_RUN: begin
                if (abort || sos_det) begin
                    gen_load = 1'b1;
                    blk_clr  = 1'b1;
                end else begin
                    accept = bit_vld;
                end
            end
            default: begin
                gen_load = 1'b1;
                blk_clr  = 1'b1;
            end
        endcase
    end

    assign state = state_q;

    // R9 R10: any abort lands in hunting
    a_r9_abort_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_HUNT));

    // R11: abort beats start in the same cycle
    a_r11_abort_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && sos_det) |=> (state_q == ST_HUNT));

endmodule

// File: rtl/tc_derand.sv
module tc_derand
    import tc_derand_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                derand_en,
    input  logic                sos_det,
    input  logic                dec_fail,
    input  logic                chan_lost,
    input  logic                bit_vld,
    input  logic                bit_in,
    output logic                blk_vld,
    output logic [BLK_BITS-1:0] blk_data
);

    tc_state_e           state;
    logic                gen_load;
    logic                accept;
    logic                blk_clr;
    logic                pat_bit;
    logic [GEN_W-1:0]    gen_state;
    logic                plain_bit;

    tc_derand_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sos_det   (sos_det),
        .dec_fail  (dec_fail),
        .chan_lost (chan_lost),
        .bit_vld   (bit_vld),
        .state     (state),
        .gen_load  (gen_load),
        .accept    (accept),
        .blk_clr   (blk_clr)
    );

    tc_derand_gen #(
        .W    (GEN_W),
        .TAPS (GEN_TAPS)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (gen_load),
        .step      (accept),
        .pat_bit   (pat_bit),
        .gen_state (gen_state)
    );

    assign plain_bit = bit_in ^ (derand_en & pat_bit);

    tc_derand_deser #(
        .N (BLK_BITS)
    ) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (blk_clr),
        .shift    (accept),
        .din      (plain_bit),
        .blk_vld  (blk_vld),
        .blk_data (blk_data)
    );

    // R1 R2: generator rests at all-ones while hunting
    a_r2_hunt_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (gen_state == '1));

    // R3: a clean start reloads the generator and enters the run state
    a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sos_det && !dec_fail && !chan_lost) |=> ((state == ST_RUN) && (gen_state == '1)));

    // R7: completion strobe lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |=> !blk_vld);

    // R2: blocks only come out of a running frame
    a_r2_vld_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |-> ($past(state) == ST_RUN));

    // R9 R10: no block completes right after an abort
    a_r9_no_vld_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_fail || chan_lost) |=> !blk_vld);

endmodule

// File: tb/tc_derand_tb.sv
module tc_derand_tb;

    localparam int NB = 56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          derand_en = 1'b1;
    logic          sos_det = 1'b0;
    logic          dec_fail = 1'b0;
    logic          chan_lost = 1'b0;
    logic          bit_vld = 1'b0;
    logic          bit_in = 1'b0;
    logic          blk_vld;
    logic [NB-1:0] blk_data;

    int n_checks = 0;
    int n_fail   = 0;
    int vld_seen = 0;
    bit done_run = 1'b0;

    logic [NB-1:0] exp_q[$];
    string         tag_q[$];
    logic [7:0]    m_gen = 8'hFF;

    always #2 clk = ~clk;   // 250 MHz

    tc_derand u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .derand_en (derand_en),
        .sos_det   (sos_det),
        .dec_fail  (dec_fail),
        .chan_lost (chan_lost),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .blk_vld   (blk_vld),
        .blk_data  (blk_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // model of R4
    function automatic logic [7:0] gen_next(input logic [7:0] s);
        logic fb;
        fb = s[0] ^ s[1] ^ s[2] ^ s[3] ^ s[4] ^ s[6];
        return {fb, s[7:1]};
    endfunction

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && blk_vld) begin
            vld_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected block", blk_data, '0);
            end else begin
                logic [NB-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(blk_data == e, t, "block content", blk_data, e);
            end
        end
    end

    task automatic drive(input logic v, input logic b, input logic s,
                         input logic f, input logic l);
        @(negedge clk);
        bit_vld = v; bit_in = b; sos_det = s; dec_fail = f; chan_lost = l;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic start(input logic with_bit);
        drive(with_bit, 1'b1, 1'b1, 1'b0, 1'b0);
        m_gen = 8'hFF;
        idle();
    endtask

    task automatic abort(input logic use_loss);
        drive(1'b1, 1'b1, 1'b0, !use_loss, use_loss);
        m_gen = 8'hFF;
        idle();
    endtask

    task automatic hunt_bits(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, i[0], 1'b0, 1'b0, 1'b0);
        idle();
    endtask

    task automatic partial(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, i[1], 1'b0, 1'b0, 1'b0);
            m_gen = gen_next(m_gen);
        end
        idle();
    endtask

    // send one codeblock whose restored value should equal plain
    task automatic send_block(input logic [NB-1:0] plain, input string tag);
        exp_q.push_back(plain);
        tag_q.push_back(tag);
        for (int i = NB - 1; i >= 0; i--) begin
            drive(1'b1, plain[i] ^ (derand_en & m_gen[0]), 1'b0, 1'b0, 1'b0);
            m_gen = gen_next(m_gen);
        end
        @(posedge clk); #1;
        check(blk_vld == 1'b1, "R7", "strobe after 56th bit", {55'd0, blk_vld}, 56'd1);
        @(negedge clk); bit_vld = 1'b0;
        @(posedge clk); #1;
        check(blk_vld == 1'b0, "R7", "strobe one cycle", {55'd0, blk_vld}, 56'd0);
        check(blk_data == plain, "R7", "data held", blk_data, plain);
    endtask

    initial begin
        int snap;
        repeat (3) @(posedge clk);
        #1;
        check(blk_vld == 1'b0, "R1", "reset strobe", {55'd0, blk_vld}, 56'd0);
        check(blk_data == '0, "R1", "reset data", blk_data, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2: bits while hunting are ignored
        snap = vld_seen;
        hunt_bits(60);
        repeat (3) idle();
        check(vld_seen == snap, "R2", "no block while hunting", NB'(vld_seen), NB'(snap));

        // R5 R8 R4: one frame, several patterns, generator continues
        start(1'b0);
        send_block(56'h0, "R5");
        send_block({NB{1'b1}}, "R8");
        send_block(56'hAA_5555_AAAA_55AA, "R8");
        send_block(56'h01_2345_6789_ABCD, "R4");

        // R9: decode failure mid block
        partial(20);
        abort(1'b0);
        snap = vld_seen;
        hunt_bits(40);
        check(vld_seen == snap, "R9", "hunting after failure", NB'(vld_seen), NB'(snap));
        start(1'b0);
        send_block(56'hC3_0F0F_F0F0_1234, "R9");

        // R10: channel loss mid block
        partial(33);
        abort(1'b1);
        start(1'b0);
        send_block(56'h7E_8181_7E7E_0001, "R10");

        // R3: restart mid block, bit in start cycle ignored
        partial(30);
        start(1'b1);
        send_block(56'hDE_ADBE_EF00_FACE, "R3");
        send_block(56'h12_3456_789A_BCDE, "R3");

        // R6: bypass, generator keeps advancing
        start(1'b0);
        derand_en = 1'b0;
        send_block(56'hF0_F0F0_0F0F_0F0F, "R6");
        derand_en = 1'b1;
        send_block(56'h33_CC33_CC33_CC33, "R6");

        // R11: abort and start together stay hunting
        @(negedge clk);
        sos_det = 1'b1; dec_fail = 1'b1; bit_vld = 1'b0;
        idle();
        m_gen = 8'hFF;
        snap = vld_seen;
        hunt_bits(56);
        repeat (3) idle();
        check(vld_seen == snap, "R11", "abort wins over start", NB'(vld_seen), NB'(snap));

        start(1'b0);
        send_block(56'h5A_A55A_A55A_A55A, "R11");

        repeat (4) idle();
        check(exp_q.size() == 0, "R7", "all expected blocks seen", NB'(exp_q.size()), '0);
        done_run = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule